// File: doc/BRIEF.md
# Circular Byte Buffer with Fill Threshold

This block is a single-channel ring of bytes reached through a small register-mapped bus. Software picks a power-of-two capacity between 64 and 4096 bytes at run time, pushes bytes through a data register and pops them through the same register. The current write and read positions can be read back and overwritten. A second write register combines the incoming byte with the byte already stored at the write position by exclusive-OR, so the buffer can build up a checksum or a whitened stream in place.

A fill counter tracks how many bytes are held. A comparator matches that count against a programmable limit. The match can mean "more than the limit" or "at most the limit". Sticky event flags record overflow, underflow, a new threshold match and a capacity change that threw away live data. Each flag has an enable bit, and one interrupt line carries the OR of the enabled flags. A clear command empties the ring. A prefetch command copies the byte at the read position into a peek register without consuming it.

Every bus access takes one cycle. Read data appears on `bus_rdata` in the cycle after the access and stays there until the next read.

Top module: `byte_ring_buffer`

## Requirements
- R1: After reset every position, the fill count, the peek byte, the threshold setting, the flags, the enables, the size code and `irq` are zero.
- R2: The size register (address 0, bits 2:0) selects a capacity of 64 shifted left by the code. Code 7 behaves like code 6 (4096). Positions written by software are reduced modulo the capacity. A write to the size register also sets both positions and the count to zero.
- R3: A bus write to the data register (address 3, bits 7:0) stores the byte at the write position, advances that position modulo the capacity and raises the count by one. A bus read of address 3 returns the byte at the read position, advances that position modulo the capacity and lowers the count by one.
- R4: A bus write to the combining register (address 4, bits 7:0) stores the incoming byte XORed with the byte held at the write position. The position and the count then advance as for an ordinary push.
- R5: A push while the count equals the capacity is dropped, leaves the count and the positions unchanged and sets flag bit 0 (overflow).
- R6: A pop while the count is zero returns 0, leaves the read position unchanged and sets flag bit 1 (underflow).
- R7: A software write of the write position (address 1) or the read position (address 2) makes the count equal to (write position minus read position) modulo the capacity.
- R8: The level register (address 5) returns the count in bits 12:0 and the threshold condition in bit 16. The threshold register (address 6) holds the limit in bits 11:0 and the mode in bit 12. With mode 0 the condition is count > limit; with mode 1 it is count <= limit.
- R9: Flag bit 2 (threshold event) is set in the cycle after the threshold condition goes from false to true, and not otherwise.
- R10: A write to the size register while the count is non-zero sets flag bit 3 (corrupt). The same write with an empty ring leaves bit 3 clear.
- R11: The command register (address 7) empties the ring when bit 0 is written as 1. When bit 1 is written as 1, it copies the byte at the read position into the peek register (address 8, bits 7:0) and leaves the read position and the count unchanged.
- R12: The flags (address 9, bits 3:0) stay set until software writes 1 to those bits there. The enables sit at address 10, bits 3:0. `irq` is high exactly when some flag and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read access |
| irq | output | 1 | OR of enabled sticky flags |

## Verification
The assertions check the invariants that hold on every cycle. They confirm that the count never exceeds the selected capacity and that a pop on an empty ring never moves the read position. They confirm that a set flag stays set unless its clear bit is written, and that a rising threshold condition always leaves the event flag set in the next cycle. The bench scenarios cover what only a known stored value can show. They read back stored bytes in order across the wrap, check the combined value after an XOR write, and check that offsets are reduced per size code, including the clamped code 7. They also cover both comparator polarities and the corrupt flag on a size change, and show that prefetch leaves the read position alone.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;

    localparam int BUS_W = 32;
    localparam int ADDR_W = 4;

    // Register word addresses
    localparam logic [ADDR_W-1:0] RA_CFG   = 4'd0;
    localparam logic [ADDR_W-1:0] RA_WOFF  = 4'd1;
    localparam logic [ADDR_W-1:0] RA_ROFF  = 4'd2;
    localparam logic [ADDR_W-1:0] RA_DATA  = 4'd3;
    localparam logic [ADDR_W-1:0] RA_XDATA = 4'd4;
    localparam logic [ADDR_W-1:0] RA_LEVEL = 4'd5;
    localparam logic [ADDR_W-1:0] RA_THCFG = 4'd6;
    localparam logic [ADDR_W-1:0] RA_CMD   = 4'd7;
    localparam logic [ADDR_W-1:0] RA_PEEK  = 4'd8;
    localparam logic [ADDR_W-1:0] RA_IFLAG = 4'd9;
    localparam logic [ADDR_W-1:0] RA_IEN   = 4'd10;

    // Flag bit positions
    localparam int FL_OF   = 0;
    localparam int FL_UF   = 1;
    localparam int FL_THR  = 2;
    localparam int FL_CORR = 3;
    localparam int NUM_FLAGS = 4;

    localparam int LEVEL_COND_BIT = 16;
    localparam int THR_MODE_BIT = 12;

endpackage

// File: rtl/rbuf_store.sv
module rbuf_store #(
    parameter int DATA_W = 8,
    parameter int AW = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/rbuf_thresh.sv
module rbuf_thresh #(
    parameter int CNT_W = 13,
    parameter int THR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [THR_W-1:0] limit,
    input  logic             mode_le,
    output logic             cond,
    output logic             rise
);
    logic [CNT_W-1:0] limit_ext;
    logic cond_d, cond_q;

    assign limit_ext = CNT_W'(limit);

    always_comb begin
        if (mode_le) begin
            cond = (count <= limit_ext);
        end else begin
            cond = (count > limit_ext);
        end
        cond_d = cond;
        rise = cond & ~cond_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
        end else begin
            cond_q <= cond_d;
        end
    end

endmodule

// File: rtl/rbuf_irq.sv
module rbuf_irq #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic          clr_we,
    input  logic [NF-1:0] clr_mask,
    input  logic          ien_we,
    input  logic [NF-1:0] ien_wdata,
    output logic [NF-1:0] flags,
    output logic [NF-1:0] ien,
    output logic          irq
);
    typedef struct packed {
        logic [NF-1:0] flags;
        logic [NF-1:0] ien;
    } irq_state_t;

    irq_state_t s_d, s_q;
    logic [NF-1:0] clr_eff;

    always_comb begin
        s_d = s_q;
        clr_eff = clr_we ? clr_mask : '0;
        // set wins over a clear in the same cycle
        s_d.flags = (s_q.flags & ~clr_eff) | set_i;
        if (ien_we) begin
            s_d.ien = ien_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags = s_q.flags;
    assign ien = s_q.ien;
    assign irq = |(s_q.flags & s_q.ien);

    // R12
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~clr_eff)) == $past(flags & ~clr_eff)));

endmodule

// File: rtl/byte_ring_buffer.sv
module byte_ring_buffer
    import rbuf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MIN_LOG2 = 6,
    parameter int MAX_LOG2 = 12,
    parameter int THR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int OFF_W = MAX_LOG2 + 1;
    localparam int MAX_CODE = MAX_LOG2 - MIN_LOG2;
    localparam int CODE_W = 3;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [OFF_W-1:0]  wr;
        logic [OFF_W-1:0]  rd;
        logic [OFF_W-1:0]  cnt;
        logic [THR_W-1:0]  limit;
        logic              mode_le;
        logic [DATA_W-1:0] hold;
        logic [BUS_W-1:0]  rdata;
    } ctrl_t;

    ctrl_t q, n;

    logic [CODE_W-1:0] code_eff;
    logic [OFF_W-1:0]  size;
    logic [OFF_W-1:0]  mask;
    logic              full, empty;

    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] byte_at_rd, byte_at_wr;

    logic              thr_cond, thr_rise;
    logic [NUM_FLAGS-1:0] set_fl, flags, ien;
    logic              clr_we, ien_we;
    logic              pop_empty;

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[BUS_W-1:OFF_W];

    // Capacity decode with clamp of out-of-range codes
    always_comb begin
        code_eff = (q.code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : q.code;
        size = OFF_W'(1) << (MIN_LOG2 + int'(code_eff));
        mask = size - OFF_W'(1);
        full = (q.cnt == size);
        empty = (q.cnt == '0);
    end

    rbuf_store #(
        .DATA_W (DATA_W),
        .AW     (MAX_LOG2)
    ) i_store (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (q.wr[MAX_LOG2-1:0]),
        .wdata   (mem_wdata),
        .raddr_a (q.rd[MAX_LOG2-1:0]),
        .rdata_a (byte_at_rd),
        .raddr_b (q.wr[MAX_LOG2-1:0]),
        .rdata_b (byte_at_wr)
    );

    rbuf_thresh #(
        .CNT_W (OFF_W),
        .THR_W (THR_W)
    ) i_thresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (q.cnt),
        .limit   (q.limit),
        .mode_le (q.mode_le),
        .cond    (thr_cond),
        .rise    (thr_rise)
    );

    rbuf_irq #(
        .NF (NUM_FLAGS)
    ) i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_fl),
        .clr_we    (clr_we),
        .clr_mask  (bus_wdata[NUM_FLAGS-1:0]),
        .ien_we    (ien_we),
        .ien_wdata (bus_wdata[NUM_FLAGS-1:0]),
        .flags     (flags),
        .ien       (ien),
        .irq       (irq)
    );

    always_comb begin
        n = q;
        mem_we = 1'b0;
        mem_wdata = '0;
        set_fl = '0;
        set_fl[FL_THR] = thr_rise;
        clr_we = 1'b0;
        ien_we = 1'b0;
        pop_empty = 1'b0;

        if (bus_sel && bus_wr) begin
            case (bus_addr)
                RA_CFG: begin
                    n.code = bus_wdata[CODE_W-1:0];
                    n.wr = '0;
                    n.rd = '0;
                    n.cnt = '0;
                    set_fl[FL_CORR] = !empty;
                end
                RA_WOFF: begin
                    n.wr = bus_wdata[OFF_W-1:0] & mask;
                    n.cnt = (n.wr - q.rd) & mask;
                end
                RA_ROFF: begin
                    n.rd = bus_wdata[OFF_W-1:0] & mask;
                    n.cnt = (q.wr - n.rd) & mask;
                end
                RA_DATA, RA_XDATA: begin
                    if (full) begin
                        set_fl[FL_OF] = 1'b1;
                    end else begin
                        mem_we = 1'b1;
                        if (bus_addr == RA_XDATA) begin
                            mem_wdata = bus_wdata[DATA_W-1:0] ^ byte_at_wr;
                        end else begin
                            mem_wdata = bus_wdata[DATA_W-1:0];
                        end
                        n.wr = (q.wr + OFF_W'(1)) & mask;
                        n.cnt = q.cnt + OFF_W'(1);
                    end
                end
                RA_THCFG: begin
                    n.limit = bus_wdata[THR_W-1:0];
                    n.mode_le = bus_wdata[THR_MODE_BIT];
                end
                RA_CMD: begin
                    if (bus_wdata[1]) begin
                        n.hold = byte_at_rd;
                    end
                    if (bus_wdata[0]) begin
                        n.wr = '0;
                        n.rd = '0;
                        n.cnt = '0;
                    end
                end
                RA_IFLAG: clr_we = 1'b1;
                RA_IEN:   ien_we = 1'b1;
                default: ;
            endcase
        end else if (bus_sel) begin
            n.rdata = '0;
            case (bus_addr)
                RA_CFG:   n.rdata = BUS_W'(q.code);
                RA_WOFF:  n.rdata = BUS_W'(q.wr);
                RA_ROFF:  n.rdata = BUS_W'(q.rd);
                RA_DATA: begin
                    if (empty) begin
                        set_fl[FL_UF] = 1'b1;
                        pop_empty = 1'b1;
                    end else begin
                        n.rdata = BUS_W'(byte_at_rd);
                        n.rd = (q.rd + OFF_W'(1)) & mask;
                        n.cnt = q.cnt - OFF_W'(1);
                    end
                end
                RA_LEVEL: begin
                    n.rdata = BUS_W'(q.cnt);
                    n.rdata[LEVEL_COND_BIT] = thr_cond;
                end
                RA_THCFG: begin
                    n.rdata = BUS_W'(q.limit);
                    n.rdata[THR_MODE_BIT] = q.mode_le;
                end
                RA_PEEK:  n.rdata = BUS_W'(q.hold);
                RA_IFLAG: n.rdata = BUS_W'(flags);
                RA_IEN:   n.rdata = BUS_W'(ien);
                default:  n.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign bus_rdata = q.rdata;

    // R5
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= size);

    // R6
    empty_pop_keeps_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_empty |=> (q.rd == $past(q.rd)) && (q.cnt == '0));

    // R9
    thr_rise_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thr_cond) |=> flags[FL_THR]);

    // R3
    push_moves_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == RA_DATA && !full)
        |=> (q.cnt == $past(q.cnt) + OFF_W'(1)));

endmodule

// File: tb/test_byte_ring_buffer.sv
module test_byte_ring_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [3:0] A_CFG = 4'd0, A_WOFF = 4'd1, A_ROFF = 4'd2,
        A_DATA = 4'd3, A_XDATA = 4'd4, A_LEVEL = 4'd5, A_THCFG = 4'd6,
        A_CMD = 4'd7, A_PEEK = 4'd8, A_IFLAG = 4'd9, A_IEN = 4'd10;

    always #5 clk = ~clk;

    byte_ring_buffer i_byte_ring_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {31'b0, irq}, 32'h0);
        bread(A_LEVEL, v); chk("R1 level", v, 32'h0);
        bread(A_WOFF, v);  chk("R1 woff", v, 32'h0);
        bread(A_ROFF, v);  chk("R1 roff", v, 32'h0);
        bread(A_IFLAG, v); chk("R1 flags", v, 32'h0);
        bread(A_PEEK, v);  chk("R1 peek", v, 32'h0);
        bread(A_THCFG, v); chk("R1 thcfg", v, 32'h0);
    endtask

    task automatic t_push_pop();
        logic [31:0] v;
        bwrite(A_CFG, 32'd0);
        for (int i = 0; i < 10; i++) bwrite(A_DATA, 32'(i * 3 + 1));
        bread(A_LEVEL, v); chk("R3 level after push", v & 32'h1FFF, 32'd10);
        bread(A_WOFF, v);  chk("R3 woff after push", v, 32'd10);
        for (int i = 0; i < 4; i++) begin
            bread(A_DATA, v); chk("R3 pop order", v, 32'(i * 3 + 1));
        end
        bread(A_ROFF, v);  chk("R3 roff after pop", v, 32'd4);
        bread(A_LEVEL, v); chk("R3 level after pop", v & 32'h1FFF, 32'd6);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        bwrite(A_CFG, 32'd0);
        bwrite(A_IFLAG, 32'hF);
        for (int i = 0; i < 64; i++) bwrite(A_DATA, 32'(i ^ 8'hA5));
        bread(A_IFLAG, v); chk("R5 no overflow at exactly full", v & 32'h1, 32'h0);
        bwrite(A_DATA, 32'h77);
        bread(A_IFLAG, v); chk("R5 overflow flag", v & 32'h1, 32'h1);
        bread(A_LEVEL, v); chk("R5 count held at capacity", v & 32'h1FFF, 32'd64);
        bread(A_WOFF, v);  chk("R3 woff wrapped", v, 32'd0);
        for (int i = 0; i < 64; i++) begin
            bread(A_DATA, v); chk("R5 stored bytes intact", v, 32'(i ^ 8'hA5));
        end
        bread(A_ROFF, v);  chk("R3 roff wrapped", v, 32'd0);
        bread(A_LEVEL, v); chk("R3 empty after drain", v & 32'h1FFF, 32'd0);
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        bwrite(A_CFG, 32'd0);
        for (int i = 0; i < 3; i++) bwrite(A_DATA, 32'h40 + 32'(i));
        for (int i = 0; i < 3; i++) bread(A_DATA, v);
        bwrite(A_IFLAG, 32'hF);
        bread(A_DATA, v);  chk("R6 empty pop returns zero", v, 32'h0);
        bread(A_IFLAG, v); chk("R6 underflow flag", v & 32'h2, 32'h2);
        bread(A_ROFF, v);  chk("R6 roff unchanged", v, 32'd3);
        bread(A_LEVEL, v); chk("R6 count stays zero", v & 32'h1FFF, 32'd0);
    endtask

    task automatic t_xor();
        logic [31:0] v;
        bwrite(A_CFG, 32'd0);
        bwrite(A_DATA, 32'h0F);
        bwrite(A_WOFF, 32'd0);
        bread(A_LEVEL, v); chk("R7 count after woff rewind", v & 32'h1FFF, 32'd0);
        bwrite(A_XDATA, 32'hF0);
        bread(A_LEVEL, v); chk("R4 xor write counts", v & 32'h1FFF, 32'd1);
        bread(A_WOFF, v);  chk("R4 xor write advances", v, 32'd1);
        bread(A_DATA, v);  chk("R4 combined byte", v, 32'hFF);
    endtask

    task automatic t_offsets();
        logic [31:0] v;
        bwrite(A_CFG, 32'd1);
        bwrite(A_WOFF, 32'h1FFF);
        bread(A_WOFF, v);  chk("R2 woff masked size 128", v, 32'd127);
        bread(A_LEVEL, v); chk("R7 count from woff", v & 32'h1FFF, 32'd127);
        bwrite(A_ROFF, 32'd100);
        bread(A_LEVEL, v); chk("R7 count from roff", v & 32'h1FFF, 32'd27);
        bwrite(A_CFG, 32'd6);
        bread(A_WOFF, v);  chk("R2 size write resets woff", v, 32'd0);
        bread(A_LEVEL, v); chk("R2 size write resets count", v & 32'h1FFF, 32'd0);
        bwrite(A_WOFF, 32'h1FFF);
        bread(A_WOFF, v);  chk("R2 woff masked size 4096", v, 32'd4095);
        bwrite(A_CFG, 32'd7);
        bwrite(A_ROFF, 32'h1FFE);
        bread(A_ROFF, v);  chk("R2 code 7 clamps to 4096", v, 32'd4094);
        bwrite(A_CFG, 32'd0);
        bwrite(A_WOFF, 32'h1FFF);
        bread(A_WOFF, v);  chk("R2 woff masked size 64", v, 32'd63);
    endtask

    task automatic t_threshold();
        logic [31:0] v;
        bwrite(A_CFG, 32'd0);
        bwrite(A_THCFG, 32'd2);
        bwrite(A_IFLAG, 32'hF);
        bread(A_THCFG, v); chk("R8 threshold readback", v, 32'd2);
        bwrite(A_DATA, 32'h1); bwrite(A_DATA, 32'h2);
        bread(A_LEVEL, v); chk("R8 mode0 count==limit false", v, 32'd2);
        bread(A_IFLAG, v); chk("R9 no event before crossing", v & 32'h4, 32'h0);
        bwrite(A_DATA, 32'h3);
        bread(A_LEVEL, v); chk("R8 mode0 count>limit true", v, 32'h0001_0003);
        bread(A_IFLAG, v); chk("R9 event on crossing", v & 32'h4, 32'h4);
        bwrite(A_THCFG, 32'h1002);
        bwrite(A_IFLAG, 32'hF);
        bread(A_LEVEL, v); chk("R8 mode1 count>limit false", v, 32'd3);
        bread(A_IFLAG, v); chk("R9 no event without rise", v & 32'h4, 32'h0);
        bread(A_DATA, v);
        bread(A_LEVEL, v); chk("R8 mode1 count<=limit true", v, 32'h0001_0002);
        bread(A_IFLAG, v); chk("R9 event in mode1", v & 32'h4, 32'h4);
        bwrite(A_THCFG, 32'h0FFF);
    endtask

    task automatic t_corrupt();
        logic [31:0] v;
        bwrite(A_CFG, 32'd0);
        bwrite(A_IFLAG, 32'hF);
        bwrite(A_CFG, 32'd0);
        bread(A_IFLAG, v); chk("R10 empty resize no corrupt", v & 32'h8, 32'h0);
        bwrite(A_DATA, 32'h99);
        bwrite(A_CFG, 32'd0);
        bread(A_IFLAG, v); chk("R10 resize with data corrupt", v & 32'h8, 32'h8);
        bread(A_LEVEL, v); chk("R10 resize empties", v & 32'h1FFF, 32'd0);
    endtask

    task automatic t_clear_prefetch();
        logic [31:0] v;
        bwrite(A_CFG, 32'd0);
        bwrite(A_DATA, 32'h11); bwrite(A_DATA, 32'h22); bwrite(A_DATA, 32'h33);
        bread(A_DATA, v);  chk("R11 first pop", v, 32'h11);
        bwrite(A_CMD, 32'h2);
        bread(A_PEEK, v);  chk("R11 prefetch byte", v, 32'h22);
        bread(A_ROFF, v);  chk("R11 prefetch keeps roff", v, 32'd1);
        bread(A_LEVEL, v); chk("R11 prefetch keeps count", v & 32'h1FFF, 32'd2);
        bwrite(A_CMD, 32'h1);
        bread(A_LEVEL, v); chk("R11 clear count", v & 32'h1FFF, 32'd0);
        bread(A_WOFF, v);  chk("R11 clear woff", v, 32'd0);
        bread(A_ROFF, v);  chk("R11 clear roff", v, 32'd0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        bwrite(A_CFG, 32'd0);
        bwrite(A_IEN, 32'h0);
        bwrite(A_IFLAG, 32'hF);
        bread(A_DATA, v);
        bread(A_IFLAG, v); chk("R12 underflow flag set", v & 32'h2, 32'h2);
        chk("R12 irq masked", {31'b0, irq}, 32'h0);
        bwrite(A_IEN, 32'h2);
        bread(A_IEN, v);   chk("R12 enable readback", v, 32'h2);
        chk("R12 irq enabled", {31'b0, irq}, 32'h1);
        bwrite(A_IFLAG, 32'h1);
        bread(A_IFLAG, v); chk("R12 sticky past other clear", v & 32'h2, 32'h2);
        bwrite(A_IFLAG, 32'h2);
        bread(A_IFLAG, v); chk("R12 w1c clears", v & 32'h2, 32'h0);
        chk("R12 irq drops", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_push_pop();
        t_overflow();
        t_underflow();
        t_xor();
        t_offsets();
        t_threshold();
        t_corrupt();
        t_clear_prefetch();
        t_irq();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule